// File: doc/BRIEF.md
# Memory Device Identification Readout Controller

This block models the identification readout mode of a graphics DRAM command port. It decodes the command pins (chip select, row strobe, column strobe, write enable, bank address and a 12-bit address) on every rising clock edge. It looks for an extended mode register write that sets address bit 10. After such a write, and after a turn-on latency, the 8-bit data output carries a fixed identification byte. The low nibble is the vendor code and the high nibble is the revision.

The byte stays on the bus until a later extended mode register write clears bit 10. A turn-off latency after that write, the bus returns to its idle level of all ones and the output enable drops. The only commands allowed while the mode is active or a latency is pending are no-operation and deselect, plus the disabling write while the byte is shown. Any other command raises a sticky violation flag. The offending command is otherwise ignored.

Top module: `devid_readout`

## Requirements
- R1: A synchronous active-high reset leaves `dq_out` = 8'hFF, `dq_oe` = 0 and `viol` = 0 after the next rising edge, with no latency pending.
- R2: A command is decoded only when `cs_n` = 0. {`ras_n`,`cas_n`,`we_n`} = 3'b000 is a mode register write. It is an extended write only when `ba` = 2'b01. A mode register write to any other bank has no effect on the identification mode.
- R3: From the idle state, an extended write with `addr[10]` = 1 captured at edge E makes `dq_oe` high after edge E+T_ON. Until then `dq_out` stays 8'hFF with `dq_oe` low.
- R4: While `dq_oe` is high, `dq_out[3:0]` = 4'b0010 (vendor) and `dq_out[7:4]` = 4'b0011 (revision), so the byte is 8'h32.
- R5: The byte stays driven through any number of deselect (`cs_n` = 1) or no-operation (`cs_n` = 0, {`ras_n`,`cas_n`,`we_n`} = 3'b111) cycles until an extended write with `addr[10]` = 0 arrives.
- R6: When the byte is shown, an extended write with `addr[10]` = 0 captured at edge D keeps the byte for T_OFF more cycles. After edge D+T_OFF, `dq_out` = 8'hFF and `dq_oe` = 0.
- R7: `dq_oe` is high exactly while the identification byte is on the bus. Whenever `dq_oe` is low, `dq_out` = 8'hFF.
- R8: Any command other than deselect or no-operation sets `viol` after its edge in three cases: during the turn-on delay, during the turn-off delay, or while the byte is shown (except the disabling extended write). `viol` then stays set until reset.
- R9: A violating command does not change the output state or the timing of the pending latencies.
- R10: Address bits 0 to 9 and 11 of the extended write do not affect entry into or exit from the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, selects the target mode register |
| addr | input | 12 | Address; bit 10 turns identification mode on or off |
| dq_out | output | 8 | Data bus value: identification byte or all ones |
| dq_oe | output | 1 | High while the identification byte is driven |
| viol | output | 1 | Sticky protocol violation flag |

## Verification
A bench model stores the edge numbers at which the byte must appear and leave. An enabling write at edge E gives E+T_ON, and a disabling write at edge D gives D+T_OFF. It also updates the violation flag at the edge of the offending command, so the flag is due one edge after that command, and reset takes effect after one edge. All three outputs are compared against the model at every falling edge, once the rising edge that updates them has passed. Commands are placed so that violations land in each pending window, including the edge just before the byte appears.

// File: rtl/devid_pkg.sv
package devid_pkg;

    localparam int ADDR_W   = 12;
    localparam int BANK_W   = 2;
    localparam int DQ_W     = 8;
    localparam int MODE_BIT = 10;

    localparam logic [BANK_W-1:0] EXT_BANK  = 2'b01;
    localparam logic [3:0]        VENDOR    = 4'b0010;
    localparam logic [3:0]        REVISION  = 4'b0011;
    localparam logic [DQ_W-1:0]   IDLE_BYTE = {DQ_W{1'b1}};

    typedef enum logic [1:0] {
        ID_OFF,
        ID_RAMP_ON,
        ID_SHOW,
        ID_RAMP_OFF
    } id_state_e;

    typedef enum logic [1:0] {
        OP_QUIET,
        OP_EXT_SET,
        OP_EXT_CLR,
        OP_OTHER
    } op_kind_e;

    typedef struct packed {
        logic              sel_n;
        logic              row_n;
        logic              col_n;
        logic              wr_n;
        logic [BANK_W-1:0] bank;
        logic              mode_bit;
    } cmd_pins_t;

    function automatic logic [DQ_W-1:0] id_byte();
        return {REVISION, VENDOR};
    endfunction

    function automatic op_kind_e classify(input cmd_pins_t c);
        op_kind_e k;
        if (c.sel_n)
            k = OP_QUIET;
        else if ({c.row_n, c.col_n, c.wr_n} == 3'b111)
            k = OP_QUIET;
        else if ({c.row_n, c.col_n, c.wr_n} == 3'b000 && c.bank == EXT_BANK)
            k = c.mode_bit ? OP_EXT_SET : OP_EXT_CLR;
        else
            k = OP_OTHER;
        return k;
    endfunction

endpackage

// File: rtl/devid_cmd_decode.sv
module devid_cmd_decode
    import devid_pkg::*;
(
    input  cmd_pins_t pins,
    output op_kind_e  op
);
    always_comb begin
        op = classify(pins);
    end
endmodule

// File: rtl/devid_delay.sv
module devid_delay #(
    parameter int MAXV = 4,
    localparam int CW  = (MAXV < 2) ? 1 : $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/devid_mode_fsm.sv
module devid_mode_fsm
    import devid_pkg::*;
#(
    parameter int T_ON  = 4,
    parameter int T_OFF = 3,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  op_kind_e      op,
    input  logic          done,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          bad,
    output id_state_e     state
);
    localparam logic [CW-1:0] ON_LOAD  = CW'(T_ON - 1);
    localparam logic [CW-1:0] OFF_LOAD = CW'(T_OFF - 1);

    id_state_e nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        bad      = 1'b0;
        unique case (state)
            ID_OFF: begin
                if (op == OP_EXT_SET) begin
                    nxt      = ID_RAMP_ON;
                    load     = 1'b1;
                    load_val = ON_LOAD;
                end
            end
            ID_RAMP_ON: begin
                bad = (op != OP_QUIET);
                if (done)
                    nxt = ID_SHOW;
            end
            ID_SHOW: begin
                if (op == OP_EXT_CLR) begin
                    nxt      = ID_RAMP_OFF;
                    load     = 1'b1;
                    load_val = OFF_LOAD;
                end else begin
                    bad = (op != OP_QUIET);
                end
            end
            ID_RAMP_OFF: begin
                bad = (op != OP_QUIET);
                if (done)
                    nxt = ID_OFF;
            end
            default: nxt = ID_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ID_OFF;
        else
            state <= nxt;
    end
endmodule

// File: rtl/devid_bus_drive.sv
module devid_bus_drive
    import devid_pkg::*;
(
    input  id_state_e       state,
    output logic [DQ_W-1:0] dq,
    output logic            oe
);
    always_comb begin
        oe = (state == ID_SHOW) || (state == ID_RAMP_OFF);
        dq = oe ? id_byte() : IDLE_BYTE;
    end
endmodule

// File: rtl/devid_readout.sv
module devid_readout
    import devid_pkg::*;
#(
    parameter int T_ON  = 4,
    parameter int T_OFF = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              viol
);
    localparam int LAT_MAX = (T_ON > T_OFF) ? T_ON : T_OFF;
    localparam int CW      = (LAT_MAX < 2) ? 1 : $clog2(LAT_MAX + 1);

    cmd_pins_t     pins;
    op_kind_e      op;
    id_state_e     state;
    logic          load;
    logic [CW-1:0] load_val;
    logic          done;
    logic          bad;
    logic          viol_q;

    // The remaining register fields carried with the write are not used here.
    logic unused_fields;
    assign unused_fields = ^{addr[ADDR_W-1:MODE_BIT+1], addr[MODE_BIT-1:0]};

    assign pins = '{sel_n: cs_n, row_n: ras_n, col_n: cas_n, wr_n: we_n,
                    bank: ba, mode_bit: addr[MODE_BIT]};

    devid_cmd_decode u_dec (
        .pins (pins),
        .op   (op)
    );

    devid_mode_fsm #(.T_ON(T_ON), .T_OFF(T_OFF), .CW(CW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .done     (done),
        .load     (load),
        .load_val (load_val),
        .bad      (bad),
        .state    (state)
    );

    devid_delay #(.MAXV(LAT_MAX)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    devid_bus_drive u_drv (
        .state (state),
        .dq    (dq_out),
        .oe    (dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)
            viol_q <= 1'b0;
        else if (bad)
            viol_q <= 1'b1;
    end

    assign viol = viol_q;
endmodule

// File: rtl/devid_readout_chk.sv
module devid_readout_chk
    import devid_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [DQ_W-1:0]   dq_out,
    input logic              dq_oe,
    input logic              viol
);
    logic active_cmd;
    logic rst_seen = 1'b0;

    assign active_cmd = !cs_n && !(ras_n && cas_n && we_n);

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: one edge after reset the bus is idle and the flag is clear
    p_reset_idle_r1: assert property (@(posedge clk)
        rst_seen |-> (dq_out == IDLE_BYTE && !dq_oe && !viol));

    // R7: a released bus sits at all ones
    p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> dq_out == IDLE_BYTE);

    // R4: the driven byte is revision over vendor
    p_id_byte_r4: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> dq_out == {REVISION, VENDOR});

    // R8: the flag never drops without reset
    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

    // R8: the flag rises only after a real command
    p_viol_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(viol) |-> $past(active_cmd));
endmodule

bind devid_readout devid_readout_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe),
    .viol   (viol)
);

// File: tb/sim_devid_readout.sv
`timescale 1ns/1ps
module sim_devid_readout;
    localparam int TON   = 4;
    localparam int TOFF  = 3;
    localparam int NEVER = 32'h3fff_ffff;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'b00;
    logic [11:0] addr = 12'h000;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic        viol;

    always #10 clk = ~clk;

    devid_readout #(.T_ON(TON), .T_OFF(TOFF)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol)
    );

    // behavioural reference: edge stamps of appearance and release
    integer edge_n = 0;
    integer on_at  = NEVER;
    integer off_at = NEVER;
    bit     m_en   = 1'b0;
    bit     m_viol = 1'b0;
    integer n_chk  = 0;
    integer n_fail = 0;
    bit     chk_en = 1'b0;
    bit     done   = 1'b0;
    string  cur_req = "R1";

    always @(posedge clk) begin
        integer prev;
        bit busy, ext;
        edge_n = edge_n + 1;
        prev = edge_n - 1;
        busy = !cs_n && !(ras_n && cas_n && we_n);
        ext  = !cs_n && !ras_n && !cas_n && !we_n && (ba == 2'b01);
        if (rst) begin
            m_en = 1'b0; m_viol = 1'b0; on_at = NEVER; off_at = NEVER;
        end else if (!m_en || prev >= off_at) begin
            if (ext && addr[10]) begin
                m_en = 1'b1; on_at = edge_n + TON; off_at = NEVER;
            end
        end else if (prev < on_at) begin
            if (busy) m_viol = 1'b1;
        end else if (off_at == NEVER) begin
            if (ext && !addr[10]) off_at = edge_n + TOFF;
            else if (busy) m_viol = 1'b1;
        end else begin
            if (busy) m_viol = 1'b1;
        end
    end

    always @(negedge clk) begin
        bit  e_oe;
        logic [7:0] e_dq;
        if (chk_en && !done) begin
            e_oe = m_en && (on_at <= edge_n) && (edge_n < off_at);
            e_dq = e_oe ? 8'h32 : 8'hFF;
            n_chk = n_chk + 3;
            if (dq_oe !== e_oe) begin
                n_fail++;
                $display("FAIL %s dq_oe edge %0d act=%b exp=%b", cur_req, edge_n, dq_oe, e_oe);
            end
            if (dq_out !== e_dq) begin
                n_fail++;
                $display("FAIL %s dq_out edge %0d act=%h exp=%h", cur_req, edge_n, dq_out, e_dq);
            end
            if (viol !== m_viol) begin
                n_fail++;
                $display("FAIL %s viol edge %0d act=%b exp=%b", cur_req, edge_n, viol, m_viol);
            end
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    task automatic put(input bit c, input bit r, input bit a, input bit w,
                       input logic [1:0] b, input logic [11:0] ad);
        cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % 2 == 0) put(1, 0, 0, 0, 2'b01, 12'h400);
            else            put(0, 1, 1, 1, 2'b11, 12'hABC);
        end
    endtask

    task automatic cmd(input bit r, input bit a, input bit w,
                       input logic [1:0] b, input logic [11:0] ad);
        @(negedge clk);
        put(0, r, a, w, b, ad);
        @(negedge clk);
        put(1, 1, 1, 1, 2'b00, 12'h000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        idle(2);
        chk_en = 1'b1;
        cur_req = "R1";
        do_reset();
        idle(4);

        cur_req = "R2";
        cmd(0, 0, 0, 2'b00, 12'h400);
        cmd(0, 0, 0, 2'b10, 12'hFFF);
        cmd(0, 0, 0, 2'b11, 12'h400);
        cmd(1, 0, 1, 2'b01, 12'h400);
        cmd(0, 1, 1, 2'b01, 12'h400);
        idle(8);

        cur_req = "R3";
        cmd(0, 0, 0, 2'b01, 12'h5A5);
        cur_req = "R4";
        idle(6);
        cur_req = "R5";
        idle(20);
        cur_req = "R6";
        cmd(0, 0, 0, 2'b01, 12'h3FF);
        cur_req = "R7";
        idle(6);

        cur_req = "R10";
        cmd(0, 0, 0, 2'b01, 12'h400);
        idle(5);
        cmd(0, 0, 0, 2'b01, 12'hBFF);
        idle(5);
        cmd(0, 0, 0, 2'b01, 12'hFFF);
        idle(6);
        cmd(0, 0, 0, 2'b01, 12'h000);
        idle(6);

        cur_req = "R8";
        cmd(0, 0, 0, 2'b01, 12'h400);
        cmd(1, 0, 1, 2'b10, 12'h010);
        cur_req = "R9";
        idle(8);
        cmd(0, 0, 0, 2'b01, 12'h000);
        idle(6);

        cur_req = "R1";
        do_reset();
        idle(3);

        cur_req = "R8";
        cmd(0, 0, 0, 2'b01, 12'h400);
        idle(6);
        cmd(0, 0, 0, 2'b01, 12'h400);
        cur_req = "R9";
        cmd(1, 0, 0, 2'b00, 12'h000);
        cmd(0, 0, 0, 2'b00, 12'h400);
        idle(4);
        cmd(0, 0, 0, 2'b01, 12'h000);
        idle(6);

        cur_req = "R1";
        do_reset();
        cur_req = "R8";
        cmd(0, 0, 0, 2'b01, 12'h400);
        idle(6);
        cmd(0, 0, 0, 2'b01, 12'h000);
        cmd(0, 1, 1, 2'b00, 12'h000);
        cur_req = "R9";
        idle(6);

        cur_req = "R1";
        do_reset();
        cur_req = "R3";
        cmd(0, 0, 0, 2'b01, 12'h400);
        idle(2);
        cur_req = "R8";
        @(negedge clk);
        put(0, 0, 1, 1, 2'b00, 12'h000);
        @(negedge clk);
        put(1, 1, 1, 1, 2'b00, 12'h000);
        cur_req = "R9";
        idle(4);
        cmd(0, 0, 0, 2'b01, 12'h000);
        idle(6);

        finish_up();
    end
endmodule